// File: doc/BRIEF.md
# Receive Bit-Error Policy Unit

This unit sits beside a bit-serial consumer-electronics control receiver and decides what to do when the bit-timing front end reports a fault. There are three fault kinds: a rising edge that comes too early (rise error), a bit period that is too short (short error) and one that is too long (long error). Each kind arrives as a one-cycle detect pulse. The unit also receives a flag that marks the current frame as broadcast and the full-listening mode bit. Four policy bits set the reaction: abort on rise error, error bit on rise error, error bit on long error, and a quiet-broadcast override.

The unit makes two decisions. The first is whether to ask the line driver for an error bit, which it issues as a one-cycle request that the driver stretches. The second is whether to abort reception. Both come out one clock after the detect pulse. Each fault kind also sets a sticky flag. A flag clears when a 1 is written to its clear strobe, and each flag has its own interrupt enable.

Top module: `cec_rx_errpol`

## Requirements
- R1: After reset, `errbit_req_o`, `rx_abort_o`, `err_flags_o` and `irq_o` are all 0.
- R2: A rise error pulses `rx_abort_o` one cycle later when `stop_on_rise_i` is 1. When `stop_on_rise_i` is 0 there is no abort. No other fault kind aborts.
- R3: In a non-broadcast frame, a rise error requests an error bit only when `stop_on_rise_i` and `rise_errbit_en_i` are both 1.
- R4: In a non-broadcast frame, a long error requests an error bit exactly when `long_errbit_en_i` is 1.
- R5: In a non-broadcast frame, a short error always requests an error bit, whatever `listen_all_i` is.
- R6: In a broadcast frame with `bcast_quiet_i` = 0, a rise error with `stop_on_rise_i` = 1 requests an error bit and a long error requests one. Both happen whatever the per-kind enable bits are.
- R7: In a broadcast frame with `bcast_quiet_i` = 1, no fault kind requests an error bit. The abort decision of R2 is unchanged.
- R8: In a broadcast frame with `bcast_quiet_i` = 0, a short error requests an error bit only when `listen_all_i` is 0.
- R9: `errbit_req_o` and `rx_abort_o` are registered. Each is high only in the cycle after a qualifying detect pulse.
- R10: Flag bit 0 is the rise error, bit 1 the short error and bit 2 the long error. A flag sets one cycle after its detect pulse. It stays set through further faults until a cycle in which its `flag_clr_i` bit is 1. A clear bit of 0, or the clear bit of another flag, leaves it unchanged.
- R11: When a detect pulse and the clear strobe hit the same flag in one cycle, the flag ends set.
- R12: `irq_o` is 1 exactly when some flag is set and its `irq_en_i` bit is 1. A change of `irq_en_i` takes effect without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rise_err_i | input | 1 | Rise error detect pulse |
| short_err_i | input | 1 | Short bit period detect pulse |
| long_err_i | input | 1 | Long bit period detect pulse |
| bcast_frame_i | input | 1 | Current frame is broadcast |
| listen_all_i | input | 1 | Full listening mode |
| stop_on_rise_i | input | 1 | Abort reception on rise error |
| rise_errbit_en_i | input | 1 | Error bit allowed on rise error |
| long_errbit_en_i | input | 1 | Error bit allowed on long error |
| bcast_quiet_i | input | 1 | Suppress all error bits in broadcast frames |
| flag_clr_i | input | 3 | Write-1-to-clear strobes per flag |
| irq_en_i | input | 3 | Interrupt enable per flag |
| errbit_req_o | output | 1 | One-cycle error-bit request |
| rx_abort_o | output | 1 | One-cycle reception abort request |
| err_flags_o | output | 3 | Sticky fault flags |
| irq_o | output | 1 | Masked interrupt |

## Verification
The case that needs care is a detect pulse and the software clear for the same flag landing on one edge. Set must win, or a fault can be lost. The bench drives a rise error together with that flag's clear strobe. In the same cycle it clears a different flag. It then expects the rise flag still set and the other flag gone. The case also arises when error-bit and abort requests come from several fault kinds in one cycle. The bench judges these with its own policy model, queued per cycle.

// File: rtl/cec_errpol_pkg.sv
package cec_errpol_pkg;

    localparam int unsigned NUM_ERR   = 3;
    localparam int unsigned IDX_RISE  = 0;
    localparam int unsigned IDX_SHORT = 1;
    localparam int unsigned IDX_LONG  = 2;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef struct packed {
        logic stop_on_rise;
        logic rise_errbit_en;
        logic long_errbit_en;
        logic bcast_quiet;
    } pol_cfg_t;

    typedef struct packed {
        logic errbit;
        logic abort;
    } act_t;

endpackage

// File: rtl/cec_errpol_decide.sv
module cec_errpol_decide
    import cec_errpol_pkg::*;
(
    input  err_vec_t det_i,
    input  logic     bcast_i,
    input  logic     listen_all_i,
    input  pol_cfg_t cfg_i,
    output act_t     act_o
);

    logic rise_bit, short_bit, long_bit;

    always_comb begin
        rise_bit  = 1'b0;
        short_bit = 1'b0;
        long_bit  = 1'b0;
        if (bcast_i) begin
            // broadcast override takes precedence over per-kind enables
            if (!cfg_i.bcast_quiet) begin
                rise_bit  = det_i[IDX_RISE] && cfg_i.stop_on_rise;
                long_bit  = det_i[IDX_LONG];
                short_bit = det_i[IDX_SHORT] && !listen_all_i;
            end
        end else begin
            rise_bit  = det_i[IDX_RISE] && cfg_i.stop_on_rise && cfg_i.rise_errbit_en;
            long_bit  = det_i[IDX_LONG] && cfg_i.long_errbit_en;
            short_bit = det_i[IDX_SHORT];
        end
        act_o.errbit = rise_bit || short_bit || long_bit;
        act_o.abort  = det_i[IDX_RISE] && cfg_i.stop_on_rise;
    end

endmodule

// File: rtl/cec_errpol_action_reg.sv
module cec_errpol_action_reg
    import cec_errpol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_t act_i,
    output act_t act_o
);

    typedef struct packed {
        act_t act;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.act = act_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

    // R9: a request only follows a requested action in the previous cycle
    a_r9_errbit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        act_o.errbit |-> ($past(rst_n) && $past(act_i.errbit)));

endmodule

// File: rtl/cec_errpol_flags.sv
module cec_errpol_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0] flags;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] nxt;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // set has priority over a simultaneous clear
        assign nxt[g] = set_i[g] || (st_q.flags[g] && !clr_i[g]);

        a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(set_i[g])) |-> flags_o[g]);

        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(flags_o[g]) && !$past(clr_i[g])) |-> flags_o[g]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/cec_rx_errpol.sv
module cec_rx_errpol
    import cec_errpol_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_err_i,
    input  logic               short_err_i,
    input  logic               long_err_i,
    input  logic               bcast_frame_i,
    input  logic               listen_all_i,
    input  logic               stop_on_rise_i,
    input  logic               rise_errbit_en_i,
    input  logic               long_errbit_en_i,
    input  logic               bcast_quiet_i,
    input  logic [NUM_ERR-1:0] flag_clr_i,
    input  logic [NUM_ERR-1:0] irq_en_i,
    output logic               errbit_req_o,
    output logic               rx_abort_o,
    output logic [NUM_ERR-1:0] err_flags_o,
    output logic               irq_o
);

    err_vec_t det;
    pol_cfg_t cfg;
    act_t     act_now, act_reg;

    always_comb begin
        det            = '0;
        det[IDX_RISE]  = rise_err_i;
        det[IDX_SHORT] = short_err_i;
        det[IDX_LONG]  = long_err_i;
        cfg.stop_on_rise   = stop_on_rise_i;
        cfg.rise_errbit_en = rise_errbit_en_i;
        cfg.long_errbit_en = long_errbit_en_i;
        cfg.bcast_quiet    = bcast_quiet_i;
    end

    cec_errpol_decide u_decide (
        .det_i        (det),
        .bcast_i      (bcast_frame_i),
        .listen_all_i (listen_all_i),
        .cfg_i        (cfg),
        .act_o        (act_now)
    );

    cec_errpol_action_reg u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act_now),
        .act_o (act_reg)
    );

    cec_errpol_flags #(.N(NUM_ERR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (det),
        .clr_i   (flag_clr_i),
        .flags_o (err_flags_o)
    );

    assign errbit_req_o = act_reg.errbit;
    assign rx_abort_o   = act_reg.abort;
    assign irq_o        = |(err_flags_o & irq_en_i);

    // R2: abort only after a rise error with stop enabled
    a_r2_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort_o |-> ($past(rst_n) && $past(rise_err_i) && $past(stop_on_rise_i)));

    // R7: quiet broadcast never yields an error bit
    a_r7_quiet_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bcast_frame_i) && $past(bcast_quiet_i)) |-> !errbit_req_o);

    // R3: lone non-broadcast rise error without both enables is silent
    a_r3_rise_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bcast_frame_i) && $past(rise_err_i) &&
         !$past(short_err_i) && !$past(long_err_i) &&
         !($past(stop_on_rise_i) && $past(rise_errbit_en_i))) |-> !errbit_req_o);

    // R9: error bit request is always caused by some detect pulse
    a_r9_errbit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        errbit_req_o |-> ($past(rst_n) && ($past(rise_err_i) || $past(short_err_i) || $past(long_err_i))));

endmodule

// File: tb/cec_rx_errpol_bench.sv
module cec_rx_errpol_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rise_err = 0, short_err = 0, long_err = 0;
    logic       bcast = 0, listen_all = 0;
    logic       stop_rise = 0, gen_rise = 0, gen_long = 0, quiet = 0;
    logic [2:0] clr = 0, en = 0;
    logic       errbit, abort_w, irq;
    logic [2:0] flags;

    int checks = 0;
    int errors = 0;
    logic [2:0] mdl_flags = 3'b000;

    typedef struct packed {
        logic       eb;
        logic       ab;
        logic [2:0] fl;
        logic       irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    cec_rx_errpol u_cec_rx_errpol (
        .clk(clk), .rst_n(rst_n),
        .rise_err_i(rise_err), .short_err_i(short_err), .long_err_i(long_err),
        .bcast_frame_i(bcast), .listen_all_i(listen_all),
        .stop_on_rise_i(stop_rise), .rise_errbit_en_i(gen_rise),
        .long_errbit_en_i(gen_long), .bcast_quiet_i(quiet),
        .flag_clr_i(clr), .irq_en_i(en),
        .errbit_req_o(errbit), .rx_abort_o(abort_w),
        .err_flags_o(flags), .irq_o(irq)
    );

    // det = {long, short, rise}; cfg = {stop, gen_rise, gen_long, quiet}
    task automatic cyc(input logic [2:0] det, input logic bc, input logic la,
                       input logic [3:0] cfg, input logic [2:0] c,
                       input logic [2:0] e, input string tag);
        exp_t x;
        logic s, gr, gl, q;
        @(negedge clk);
        {s, gr, gl, q} = cfg;
        rise_err = det[0]; short_err = det[1]; long_err = det[2];
        bcast = bc; listen_all = la;
        stop_rise = s; gen_rise = gr; gen_long = gl; quiet = q;
        clr = c; en = e;
        if (bc) x.eb = !q && ((det[0] && s) || det[2] || (det[1] && !la));
        else    x.eb = (det[0] && s && gr) || (det[2] && gl) || det[1];
        x.ab = det[0] && s;
        mdl_flags = (mdl_flags & ~c) | det;
        x.fl  = mdl_flags;
        x.irq = |(mdl_flags & e);
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({errbit, abort_w, flags, irq} !== x) begin
                    errors++;
                    $display("FAIL %s: got eb=%b ab=%b fl=%b irq=%b exp eb=%b ab=%b fl=%b irq=%b",
                             t, errbit, abort_w, flags, irq, x.eb, x.ab, x.fl, x.irq);
                end
            end
        end
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: got hang exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({errbit, abort_w, flags, irq} !== 6'b0) begin
            errors++;
            $display("FAIL R1: got %b exp 000000", {errbit, abort_w, flags, irq});
        end
        rst_n = 1'b1;
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b000, "R1");
        // rise error, non-broadcast
        cyc(3'b001, 0, 0, 4'b0000, 3'b000, 3'b000, "R2 no stop");
        cyc(3'b001, 0, 0, 4'b1000, 3'b111, 3'b000, "R3 stop only");
        cyc(3'b001, 0, 0, 4'b1100, 3'b111, 3'b000, "R3 stop+gen");
        cyc(3'b001, 0, 0, 4'b0100, 3'b111, 3'b000, "R3 gen only");
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b000, "R9 idle after");
        // long / short, non-broadcast
        cyc(3'b100, 0, 0, 4'b0000, 3'b111, 3'b000, "R4 gen off");
        cyc(3'b100, 0, 0, 4'b0010, 3'b111, 3'b000, "R4 gen on");
        cyc(3'b010, 0, 1, 4'b0000, 3'b111, 3'b000, "R5 listen all");
        cyc(3'b010, 0, 0, 4'b0000, 3'b111, 3'b000, "R5 reduced");
        // broadcast, override clear
        cyc(3'b001, 1, 0, 4'b1000, 3'b111, 3'b000, "R6 rise gen off");
        cyc(3'b001, 1, 0, 4'b0000, 3'b111, 3'b000, "R6 rise no stop");
        cyc(3'b100, 1, 0, 4'b0000, 3'b111, 3'b000, "R6 long gen off");
        cyc(3'b010, 1, 1, 4'b0000, 3'b111, 3'b000, "R8 listen all");
        cyc(3'b010, 1, 0, 4'b0000, 3'b111, 3'b000, "R8 reduced");
        // broadcast, quiet
        cyc(3'b001, 1, 0, 4'b1101, 3'b111, 3'b000, "R7 rise");
        cyc(3'b100, 1, 0, 4'b0011, 3'b111, 3'b000, "R7 long");
        cyc(3'b111, 1, 0, 4'b1111, 3'b111, 3'b000, "R7 all");
        // flags and interrupt
        cyc(3'b000, 0, 0, 4'b0000, 3'b111, 3'b000, "R10 clear all");
        cyc(3'b010, 0, 0, 4'b0000, 3'b000, 3'b000, "R10 set short");
        cyc(3'b010, 0, 0, 4'b0000, 3'b000, 3'b000, "R10 repeat");
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b101, "R12 masked");
        cyc(3'b000, 0, 0, 4'b0000, 3'b101, 3'b010, "R10 other clears");
        cyc(3'b100, 0, 0, 4'b0000, 3'b000, 3'b000, "R10 add long");
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b100, "R12 long enabled");
        cyc(3'b001, 0, 0, 4'b1100, 3'b011, 3'b001, "R11 set vs clr");
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b001, "R11 hold");
        cyc(3'b101, 0, 0, 4'b1110, 3'b000, 3'b111, "R2 multi");
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b111, "R9 pulse ends");
        cyc(3'b000, 0, 0, 4'b0000, 3'b111, 3'b111, "R10 clear final");
        cyc(3'b000, 0, 0, 4'b0000, 3'b000, 3'b000, "R12 idle");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule